// File: doc/BRIEF.md
# Four-Mode Program Bank Translator

This block turns a CPU access in the upper 32 KB program window into a physical address. The access goes either to cartridge program ROM or to an on-board work RAM. A 2-bit mode sets the granularity of the window. The window can be one 32 KB region, two 16 KB halves, one 16 KB half followed by two 8 KB slots, or four 8 KB slots. The same four 8-bit bank registers feed every mode. In the coarser modes the bank indices are shifted right.

For every slot except the topmost one, the top bit of the controlling bank register picks the target. A value of 1 selects ROM and a value of 0 selects work RAM, which has eight 8 KB pages. The topmost 8 KB slot at CPU offset 0x6000 within the window (CPU address 0xE000) always reads ROM. The block therefore always exposes a fixed bank there.

A small configuration port loads the four bank registers and the mode. Translation is combinational from the stored configuration and the CPU address. A configuration write takes effect on the clock edge that captures it.

Top module: `prg_bank_unit`

## Requirements
- R1: After synchronous reset the mode is 3 (four 8 KB slots), bank register 3 holds 0xFF and bank registers 0 to 2 hold 0x00. So slot 3 maps ROM page 0x7F and slots 0 to 2 map RAM page 0.
- R2: When `cfg_we` is high at a rising edge, `cfg_sel` values 0 to 3 load bank register 0 to 3 from `cfg_data`, and `cfg_sel` 4 loads the mode from `cfg_data[1:0]`. `cfg_sel` values 5 to 7 change nothing. The new value is used from that edge onward.
- R3: Mode 0: every slot maps ROM, and the 8 KB ROM page is {reg3[6:2], cpu_addr[14:13]}.
- R4: Mode 1: the upper 16 KB (cpu_addr[14]=1) maps ROM page {reg3[6:1], cpu_addr[13]}. The lower 16 KB maps ROM page {reg1[6:1], cpu_addr[13]} when reg1[7]=1, and RAM page {reg1[2:1], cpu_addr[13]} when reg1[7]=0.
- R5: Mode 2: the lower 16 KB follows the R4 rule with reg1. Slot 2 maps ROM page reg2[6:0] when reg2[7]=1 and RAM page reg2[2:0] otherwise. Slot 3 maps ROM page reg3[6:0].
- R6: Mode 3: slot n (n = 0..2) maps ROM page regn[6:0] when regn[7]=1 and RAM page regn[2:0] otherwise. Slot 3 maps ROM page reg3[6:0].
- R7: On a ROM mapping `map_is_ram` is 0 and `rom_addr` = {7-bit ROM page, cpu_addr[12:0]}. Bit 7 of a bank register never reaches a ROM page.
- R8: On a RAM mapping `map_is_ram` is 1 and `ram_addr` = {3-bit RAM page, cpu_addr[12:0]}.
- R9: Slot 3 (cpu_addr[14:13]=3) maps ROM in every mode.
- R10: `ram_we` = `cpu_req` AND `cpu_wr` AND `map_is_ram`. A write to a slot mapped to ROM raises no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0-3 bank register, 4 mode, 5-7 none |
| cfg_data | input | 8 | Configuration write data |
| cpu_req | input | 1 | CPU access valid in the program window |
| cpu_wr | input | 1 | CPU access is a write |
| cpu_addr | input | 15 | CPU address offset within the 32 KB window |
| map_is_ram | output | 1 | 1 when the access targets work RAM |
| rom_addr | output | 20 | Translated ROM byte address |
| ram_addr | output | 16 | Translated work-RAM byte address |
| ram_we | output | 1 | Work-RAM write enable |

## Verification
Some rules are checked by assertions on every cycle. These cover the load of each configuration register, the fixed ROM mapping of slot 3, the absence of RAM targets in mode 0, and the gating of the write enable. Only the bench's scenarios can show that page numbers come out right. That covers the shifting and concatenation in each mode, the bit-7 stripping, the reset contents seen through the address outputs, and that unused select codes leave the mapping untouched. For this the bench compares against a model, over random configurations and addresses mixed with directed corners.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int ROM_PAGE_W = REG_W - 1;
    localparam int RAM_PAGE_W = 3;
    localparam int OFS_W      = 13;
    localparam int WIN_W      = OFS_W + SLOT_W;
    localparam int ROM_AW     = ROM_PAGE_W + OFS_W;
    localparam int RAM_AW     = RAM_PAGE_W + OFS_W;
    localparam int CFG_SEL_W  = 3;
    localparam int MODE_SEL   = NUM_SLOTS;
    localparam int SEL_BIT    = REG_W - 1;

    typedef enum logic [1:0] {
        PM_32K  = 2'd0,
        PM_16K  = 2'd1,
        PM_16_8 = 2'd2,
        PM_8K   = 2'd3
    } prg_mode_e;

    typedef logic [REG_W-1:0] bank_reg_t;

    typedef struct packed {
        logic                  is_ram;
        logic [ROM_PAGE_W-1:0] rom_page;
        logic [RAM_PAGE_W-1:0] ram_page;
    } slot_map_t;

    // Fixed ROM mapping at 8 KB granularity
    function automatic slot_map_t rom_fixed(logic [ROM_PAGE_W-1:0] page);
        slot_map_t m;
        m.is_ram   = 1'b0;
        m.rom_page = page;
        m.ram_page = '0;
        return m;
    endfunction

    // 8 KB slot that the top bit may redirect to work RAM
    function automatic slot_map_t slot8(bank_reg_t r);
        slot_map_t m;
        m.is_ram   = ~r[SEL_BIT];
        m.rom_page = r[ROM_PAGE_W-1:0];
        m.ram_page = r[RAM_PAGE_W-1:0];
        return m;
    endfunction

    // One 8 KB half of a 16 KB slot; sub picks the half
    function automatic slot_map_t slot16(bank_reg_t r, logic sub);
        slot_map_t m;
        m.is_ram   = ~r[SEL_BIT];
        m.rom_page = {r[ROM_PAGE_W-1:1], sub};
        m.ram_page = {r[RAM_PAGE_W-1:1], sub};
        return m;
    endfunction

    function automatic slot_map_t map_slot(prg_mode_e mode, bank_reg_t r0, bank_reg_t r1,
                                           bank_reg_t r2, bank_reg_t r3,
                                           logic [SLOT_W-1:0] slot);
        slot_map_t m;
        case (mode)
            PM_32K:  m = rom_fixed({r3[ROM_PAGE_W-1:2], slot});
            PM_16K:  m = slot[1] ? rom_fixed({r3[ROM_PAGE_W-1:1], slot[0]})
                                 : slot16(r1, slot[0]);
            PM_16_8: begin
                case (slot)
                    2'd2:    m = slot8(r2);
                    2'd3:    m = rom_fixed(r3[ROM_PAGE_W-1:0]);
                    default: m = slot16(r1, slot[0]);
                endcase
            end
            default: begin
                case (slot)
                    2'd0:    m = slot8(r0);
                    2'd1:    m = slot8(r1);
                    2'd2:    m = slot8(r2);
                    default: m = rom_fixed(r3[ROM_PAGE_W-1:0]);
                endcase
            end
        endcase
        return m;
    endfunction
endpackage

// File: rtl/pbu_cfg_regs.sv
module pbu_cfg_regs
    import pbu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CFG_SEL_W-1:0]          cfg_sel,
    input  logic [REG_W-1:0]              cfg_data,
    output prg_mode_e                     mode,
    output bank_reg_t [NUM_SLOTS-1:0]     banks
);
    localparam bank_reg_t LAST_RST = '1;

    always_ff @(posedge clk) begin
        if (rst)
            mode <= PM_8K;
        else if (cfg_we && cfg_sel == CFG_SEL_W'(MODE_SEL))
            mode <= prg_mode_e'(cfg_data[1:0]);
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bank
        localparam bank_reg_t RST_VAL = (g == NUM_SLOTS - 1) ? LAST_RST : '0;
        always_ff @(posedge clk) begin
            if (rst)
                banks[g] <= RST_VAL;
            else if (cfg_we && cfg_sel == CFG_SEL_W'(g))
                banks[g] <= cfg_data;
        end

        p_bank_load_r2: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_sel == CFG_SEL_W'(g)) |=> banks[g] == $past(cfg_data));
        p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
            !(cfg_we && cfg_sel == CFG_SEL_W'(g)) |=> $stable(banks[g]));
    end

    p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == CFG_SEL_W'(MODE_SEL)) |=> mode == prg_mode_e'($past(cfg_data[1:0])));
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_sel == CFG_SEL_W'(MODE_SEL)) |=> $stable(mode));
endmodule

// File: rtl/pbu_slot_table.sv
module pbu_slot_table
    import pbu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  prg_mode_e                     mode,
    input  bank_reg_t [NUM_SLOTS-1:0]     banks,
    output slot_map_t [NUM_SLOTS-1:0]     maps
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign maps[g] = map_slot(mode, banks[0], banks[1], banks[2], banks[3], SLOT_W'(g));
    end

    p_last_slot_rom_r9: assert property (@(posedge clk) disable iff (rst)
        !maps[NUM_SLOTS-1].is_ram);
    p_mode0_no_ram_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_32K) |-> (maps[0].is_ram | maps[1].is_ram | maps[2].is_ram) == 1'b0);
    p_mode1_upper_rom_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_16K) |-> !maps[2].is_ram);
endmodule

// File: rtl/prg_bank_unit.sv
module prg_bank_unit
    import pbu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [7:0]            cfg_data,
    input  logic                  cpu_req,
    input  logic                  cpu_wr,
    input  logic [14:0]           cpu_addr,
    output logic                  map_is_ram,
    output logic [19:0]           rom_addr,
    output logic [15:0]           ram_addr,
    output logic                  ram_we
);
    prg_mode_e                 mode;
    bank_reg_t [NUM_SLOTS-1:0] banks;
    slot_map_t [NUM_SLOTS-1:0] maps;
    slot_map_t                 cur;
    logic [SLOT_W-1:0]         slot;
    logic [OFS_W-1:0]          ofs;

    pbu_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .mode     (mode),
        .banks    (banks)
    );

    pbu_slot_table u_table (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .banks (banks),
        .maps  (maps)
    );

    assign slot = cpu_addr[WIN_W-1:OFS_W];
    assign ofs  = cpu_addr[OFS_W-1:0];
    assign cur  = maps[slot];

    assign map_is_ram = cur.is_ram;
    assign rom_addr   = {cur.rom_page, ofs};
    assign ram_addr   = {cur.ram_page, ofs};
    assign ram_we     = cpu_req & cpu_wr & cur.is_ram;

    p_rom_write_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !map_is_ram) |-> !ram_we);
    p_we_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_req && cpu_wr));
    p_top_slot_rom_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[14:13] == 2'd3) |-> !map_is_ram);
    p_offset_passes_r7: assert property (@(posedge clk) disable iff (rst)
        rom_addr[12:0] == cpu_addr[12:0] && ram_addr[12:0] == cpu_addr[12:0]);
endmodule

// File: tb/prg_bank_unit_bench.sv
module prg_bank_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [7:0]  cfg_data;
    logic        cpu_req;
    logic        cpu_wr;
    logic [14:0] cpu_addr;
    logic        map_is_ram;
    logic [19:0] rom_addr;
    logic [15:0] ram_addr;
    logic        ram_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [1:0] m_mode;
    logic [7:0] m_reg [4];

    always #2 clk = ~clk;

    prg_bank_unit u_prg_bank_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .map_is_ram(map_is_ram), .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_we(ram_we)
    );

    // Model of the requirements, region by region
    task automatic model(input logic [14:0] a, output logic e_ram,
                         output logic [19:0] e_rom, output logic [15:0] e_rama);
        e_ram = 0; e_rom = '0; e_rama = '0;
        case (m_mode)
            2'd0: e_rom = {m_reg[3][6:2], a};                         // R3
            2'd1, 2'd2: begin
                if (!a[14]) begin                                      // R4 lower half
                    if (m_reg[1][7]) e_rom = {m_reg[1][6:1], a[13:0]};
                    else begin e_ram = 1; e_rama = {m_reg[1][2:1], a[13:0]}; end
                end else if (m_mode == 2'd1) begin
                    e_rom = {m_reg[3][6:1], a[13:0]};
                end else if (!a[13]) begin                             // R5 slot 2
                    if (m_reg[2][7]) e_rom = {m_reg[2][6:0], a[12:0]};
                    else begin e_ram = 1; e_rama = {m_reg[2][2:0], a[12:0]}; end
                end else e_rom = {m_reg[3][6:0], a[12:0]};
            end
            default: begin                                             // R6
                if (a[14:13] == 2'd3) e_rom = {m_reg[3][6:0], a[12:0]};
                else if (m_reg[a[14:13]][7]) e_rom = {m_reg[a[14:13]][6:0], a[12:0]};
                else begin e_ram = 1; e_rama = {m_reg[a[14:13]][2:0], a[12:0]}; end
            end
        endcase
    endtask

    task automatic check(input string req, input logic [14:0] a, input logic rq, input logic wr);
        logic e_ram; logic [19:0] e_rom; logic [15:0] e_rama; logic e_we;
        @(negedge clk);
        cpu_addr = a; cpu_req = rq; cpu_wr = wr;
        #1;
        model(a, e_ram, e_rom, e_rama);
        e_we = rq & wr & e_ram;
        n_checks++;
        if (map_is_ram !== e_ram || ram_we !== e_we ||
            (!e_ram && rom_addr !== e_rom) || (e_ram && ram_addr !== e_rama)) begin
            n_fail++;
            $display("FAIL %s addr=%h mode=%0d: ram=%b we=%b rom=%h rama=%h expected ram=%b we=%b rom=%h rama=%h",
                     req, a, m_mode, map_is_ram, ram_we, rom_addr, ram_addr, e_ram, e_we, e_rom, e_rama);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
        if (sel < 3'd4) m_reg[sel[1:0]] = d;
        else if (sel == 3'd4) m_mode = d[1:0];
    endtask

    task automatic all_slots(input string req);
        for (int s = 0; s < 4; s++) check(req, {s[1:0], 13'h0A5 + 13'(s * 37)}, 1'b1, 1'b1);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_data = 0;
        cpu_req = 0; cpu_wr = 0; cpu_addr = 0;
        m_mode = 2'd3; m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset mapping: slots 0..2 RAM page 0, slot 3 ROM page 0x7F
        all_slots("R1");
        // R2: unused selects change nothing
        cfg(3'd5, 8'h81); cfg(3'd6, 8'h02); cfg(3'd7, 8'hC3);
        all_slots("R2");
        // R3 mode 0 with bit 7 set on reg3 (R7 stripping)
        cfg(3'd4, 8'h00); cfg(3'd3, 8'hB6);
        all_slots("R3");
        // R4 mode 1, lower half RAM then ROM
        cfg(3'd4, 8'h01); cfg(3'd1, 8'h07);
        all_slots("R4");
        cfg(3'd1, 8'hFB);
        all_slots("R4");
        // R5 mode 2, slot 2 RAM then ROM
        cfg(3'd4, 8'h02); cfg(3'd2, 8'h7D);
        all_slots("R5");
        cfg(3'd2, 8'h9A);
        all_slots("R5");
        // R6 mode 3, mixed targets, R9 reg3 bit 7 clear still ROM
        cfg(3'd4, 8'h03); cfg(3'd0, 8'hC4); cfg(3'd1, 8'h2E); cfg(3'd2, 8'h80); cfg(3'd3, 8'h15);
        all_slots("R6");
        // R10 reads and idle do not enable writes
        check("R10", 15'h2001, 1'b1, 1'b0);
        check("R10", 15'h2002, 1'b0, 1'b1);
        check("R10", 15'h0003, 1'b1, 1'b1);
        // R8/R7 random configurations and accesses
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) cfg(3'($urandom_range(0, 7)), 8'($urandom));
            check(((i % 2) == 0) ? "R7" : "R8", 15'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual not done expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule